// File: doc/BRIEF.md
# Flash Erase and Program-Write Sequencer

This block sits between the special-function-register bus of a small 8-bit processor and an on-chip 64 KB flash array, which is organised as 128 pages of 512 bytes. It guards erase operations with an unlock protocol. A mass erase must first be armed by setting an enable bit in the control register. A page erase must first be armed by writing the page register. Either erase then starts only when the matching key byte is written to the key register. A wrong key, or a key written with nothing armed, is thrown away and disarms the block. The mass erase additionally requires the debug-port enable input.

The block also routes the processor's external-data store cycles. When the program-write-enable bit is clear, stores go to data RAM. When it is set, stores become flash program writes. These flash writes are allowed only while the clock-rate-ok input is high, interrupts are reported disabled and no erase is running. Setting program-write-enable while interrupts are still enabled raises a sticky protocol-error flag. A busy flag covers each erase, from its launch until the flash macro reports completion.

Top module: `flash_seq_ctrl`

## Requirements
- R1: After reset, busy_o, proto_err_o, the erase strobes, ram_we_o and fl_prog_o are low, and the control register reads 0x00. The control register layout is: bit0 program-write-enable, bit1 mass-erase enable, bit2 busy (read-only), bit3 protocol error (read-only; writing 1 clears it).
- R2: Writing the control register (address 0xC0) with bit1 set arms a mass erase, and bit1 reads back as 1. A following write of 0xAA to the key register (0xC1), made while dbg_en_i and clk_ok_i are high, pulses fl_mass_erase_o for one cycle. On that same edge busy_o rises and bit1 self-clears.
- R3: If dbg_en_i is low when 0xAA is written to an armed key register, no mass erase starts, busy_o stays low and the mass arming is cleared.
- R4: A write to the page register (0xC2) followed by a write of 0x55 to the key register, with clk_ok_i high, pulses fl_page_erase_o for one cycle. fl_page_o then carries bits 7:1 of the page value written, and those bits address flash bits 15:9.
- R5: A key write that does not match the armed erase type, or any key write made while nothing is armed, starts nothing and clears the arming. A correct key written afterwards then has no effect.
- R6: While clk_ok_i is low, erase requests are blocked and a store with program-write-enable set does not assert fl_prog_o.
- R7: busy_o stays high until fl_done_i is sampled high, and it clears on that edge. While busy, page, arming and key writes are ignored.
- R8: While program-write-enable is clear, a store asserts ram_we_o and not fl_prog_o. While it is set, the store asserts fl_prog_o with the store address and data on fl_addr_o and fl_wdata_o, and does not assert ram_we_o.
- R9: While program-write-enable is set and irq_off_i is low, proto_err_o becomes set one edge later and flash program writes are blocked. Writing the control register with bit3 set clears the flag once the condition is gone.
- R10: The page register reads back as the latched 7-bit page in bits 7:1, with bit0 reading 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sfr_we_i | input | 1 | Register write strobe |
| sfr_addr_i | input | 8 | Register address |
| sfr_wdata_i | input | 8 | Register write data |
| sfr_rdata_o | output | 8 | Read data for the addressed register |
| dbg_en_i | input | 1 | Debug port enabled; required for mass erase |
| clk_ok_i | input | 1 | CPU clock is at the programming rate |
| irq_off_i | input | 1 | Interrupts are globally disabled |
| xst_we_i | input | 1 | External-data store strobe |
| xst_addr_i | input | 16 | Store address |
| xst_wdata_i | input | 8 | Store data |
| ram_we_o | output | 1 | Data RAM write enable |
| ram_addr_o | output | 16 | Data RAM address |
| ram_wdata_o | output | 8 | Data RAM write data |
| fl_prog_o | output | 1 | Flash program write request |
| fl_addr_o | output | 16 | Flash program address |
| fl_wdata_o | output | 8 | Flash program data |
| fl_mass_erase_o | output | 1 | One-cycle mass erase strobe |
| fl_page_erase_o | output | 1 | One-cycle page erase strobe |
| fl_page_o | output | 7 | Latched page number (flash address bits 15:9) |
| fl_done_i | input | 1 | Flash macro reports the erase finished |
| busy_o | output | 1 | Erase in progress |
| proto_err_o | output | 1 | Sticky protocol error |

## Verification
The assertions assume that fl_done_i is only meaningful while an erase is in flight, and that the processor issues at most one register write per cycle. The bench honours both conditions. It changes every input on the falling clock edge, raises fl_done_i only after it has seen busy_o high, and holds each register write for exactly one rising edge. The gating inputs dbg_en_i, clk_ok_i and irq_off_i are changed only between register writes, so each check sees one stable condition.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;
  typedef enum logic [1:0] {
    ARM_NONE = 2'd0,
    ARM_MASS = 2'd1,
    ARM_PAGE = 2'd2
  } arm_e;

  localparam logic [7:0] MASS_KEY = 8'hAA;
  localparam logic [7:0] PAGE_KEY = 8'h55;

  localparam int CTL_PWE  = 0;
  localparam int CTL_MEN  = 1;
  localparam int CTL_BUSY = 2;
  localparam int CTL_ERR  = 3;
endpackage

// File: rtl/flash_seq_regs.sv
module flash_seq_regs
  import flash_seq_pkg::*;
#(
  parameter int          PAGE_W    = 7,
  parameter logic [7:0]  ADDR_CTL  = 8'hC0,
  parameter logic [7:0]  ADDR_KEY  = 8'hC1,
  parameter logic [7:0]  ADDR_PAGE = 8'hC2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sfr_we_i,
  input  logic [7:0]        sfr_addr_i,
  input  logic [7:0]        sfr_wdata_i,
  input  logic              irq_off_i,
  input  logic              mass_armed_i,
  input  logic              busy_i,
  output logic              wr_ctl_o,
  output logic              wr_key_o,
  output logic              wr_page_o,
  output logic              pwe_o,
  output logic              err_o,
  output logic [PAGE_W-1:0] page_o,
  output logic [7:0]        rdata_o
);
  localparam int PAD_W = 8 - PAGE_W;

  logic              pwe_q, err_q;
  logic [PAGE_W-1:0] page_q;

  assign wr_ctl_o  = sfr_we_i && (sfr_addr_i == ADDR_CTL);
  assign wr_key_o  = sfr_we_i && (sfr_addr_i == ADDR_KEY);
  assign wr_page_o = sfr_we_i && (sfr_addr_i == ADDR_PAGE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pwe_q  <= 1'b0;
      err_q  <= 1'b0;
      page_q <= '0;
    end else begin
      if (wr_ctl_o) pwe_q <= sfr_wdata_i[CTL_PWE];
      // set wins over write-1-to-clear
      if (pwe_q && !irq_off_i)                err_q <= 1'b1;
      else if (wr_ctl_o && sfr_wdata_i[CTL_ERR]) err_q <= 1'b0;
      if (wr_page_o && !busy_i) page_q <= sfr_wdata_i[7 -: PAGE_W];
    end
  end

  always_comb begin
    rdata_o = 8'h00;
    if (sfr_addr_i == ADDR_CTL) begin
      rdata_o[CTL_PWE]  = pwe_q;
      rdata_o[CTL_MEN]  = mass_armed_i;
      rdata_o[CTL_BUSY] = busy_i;
      rdata_o[CTL_ERR]  = err_q;
    end else if (sfr_addr_i == ADDR_PAGE) begin
      rdata_o = {page_q, {PAD_W{1'b0}}};
    end
  end

  assign pwe_o  = pwe_q;
  assign err_o  = err_q;
  assign page_o = page_q;
endmodule

// File: rtl/flash_seq_erase.sv
module flash_seq_erase
  import flash_seq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_ctl_i,
  input  logic       wr_key_i,
  input  logic       wr_page_i,
  input  logic [7:0] wdata_i,
  input  logic       dbg_en_i,
  input  logic       clk_ok_i,
  input  logic       done_i,
  output logic       mass_armed_o,
  output logic       busy_o,
  output logic       mass_stb_o,
  output logic       page_stb_o
);
  arm_e arm_q;
  logic busy_q, mass_q, page_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      arm_q  <= ARM_NONE;
      busy_q <= 1'b0;
      mass_q <= 1'b0;
      page_q <= 1'b0;
    end else begin
      mass_q <= 1'b0;
      page_q <= 1'b0;
      if (busy_q) begin
        if (done_i) busy_q <= 1'b0;
      end else if (wr_key_i) begin
        // every key write disarms, match or not
        arm_q <= ARM_NONE;
        if (arm_q == ARM_MASS && wdata_i == MASS_KEY && dbg_en_i && clk_ok_i) begin
          mass_q <= 1'b1;
          busy_q <= 1'b1;
        end else if (arm_q == ARM_PAGE && wdata_i == PAGE_KEY && clk_ok_i) begin
          page_q <= 1'b1;
          busy_q <= 1'b1;
        end
      end else if (wr_ctl_i) begin
        if (wdata_i[CTL_MEN])       arm_q <= ARM_MASS;
        else if (arm_q == ARM_MASS) arm_q <= ARM_NONE;
      end else if (wr_page_i) begin
        arm_q <= ARM_PAGE;
      end
    end
  end

  assign mass_armed_o = (arm_q == ARM_MASS);
  assign busy_o       = busy_q;
  assign mass_stb_o   = mass_q;
  assign page_stb_o   = page_q;
endmodule

// File: rtl/flash_seq_steer.sv
module flash_seq_steer #(
  parameter int ADDR_W = 16
) (
  input  logic              pwe_i,
  input  logic              clk_ok_i,
  input  logic              irq_off_i,
  input  logic              busy_i,
  input  logic              xst_we_i,
  input  logic [ADDR_W-1:0] xst_addr_i,
  input  logic [7:0]        xst_wdata_i,
  output logic              ram_we_o,
  output logic [ADDR_W-1:0] ram_addr_o,
  output logic [7:0]        ram_wdata_o,
  output logic              fl_prog_o,
  output logic [ADDR_W-1:0] fl_addr_o,
  output logic [7:0]        fl_wdata_o
);
  logic fl_ok;
  assign fl_ok = clk_ok_i && irq_off_i && !busy_i;

  // a blocked flash store is dropped, never redirected to RAM
  assign ram_we_o    = xst_we_i && !pwe_i;
  assign fl_prog_o   = xst_we_i && pwe_i && fl_ok;
  assign ram_addr_o  = xst_addr_i;
  assign ram_wdata_o = xst_wdata_i;
  assign fl_addr_o   = xst_addr_i;
  assign fl_wdata_o  = xst_wdata_i;
endmodule

// File: rtl/flash_seq_ctrl.sv
module flash_seq_ctrl
  import flash_seq_pkg::*;
#(
  parameter int         ADDR_W     = 16,
  parameter int         PAGE_LOG2  = 9,
  parameter logic [7:0] ADDR_CTL   = 8'hC0,
  parameter logic [7:0] ADDR_KEY   = 8'hC1,
  parameter logic [7:0] ADDR_PAGE  = 8'hC2,
  localparam int        PAGE_W     = ADDR_W - PAGE_LOG2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sfr_we_i,
  input  logic [7:0]        sfr_addr_i,
  input  logic [7:0]        sfr_wdata_i,
  output logic [7:0]        sfr_rdata_o,
  input  logic              dbg_en_i,
  input  logic              clk_ok_i,
  input  logic              irq_off_i,
  input  logic              xst_we_i,
  input  logic [ADDR_W-1:0] xst_addr_i,
  input  logic [7:0]        xst_wdata_i,
  output logic              ram_we_o,
  output logic [ADDR_W-1:0] ram_addr_o,
  output logic [7:0]        ram_wdata_o,
  output logic              fl_prog_o,
  output logic [ADDR_W-1:0] fl_addr_o,
  output logic [7:0]        fl_wdata_o,
  output logic              fl_mass_erase_o,
  output logic              fl_page_erase_o,
  output logic [PAGE_W-1:0] fl_page_o,
  input  logic              fl_done_i,
  output logic              busy_o,
  output logic              proto_err_o
);
  logic wr_ctl, wr_key, wr_page, pwe, mass_armed, busy;

  flash_seq_regs #(
    .PAGE_W(PAGE_W), .ADDR_CTL(ADDR_CTL), .ADDR_KEY(ADDR_KEY), .ADDR_PAGE(ADDR_PAGE)
  ) u_regs (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .sfr_we_i     (sfr_we_i),
    .sfr_addr_i   (sfr_addr_i),
    .sfr_wdata_i  (sfr_wdata_i),
    .irq_off_i    (irq_off_i),
    .mass_armed_i (mass_armed),
    .busy_i       (busy),
    .wr_ctl_o     (wr_ctl),
    .wr_key_o     (wr_key),
    .wr_page_o    (wr_page),
    .pwe_o        (pwe),
    .err_o        (proto_err_o),
    .page_o       (fl_page_o),
    .rdata_o      (sfr_rdata_o)
  );

  flash_seq_erase u_erase (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_ctl_i     (wr_ctl),
    .wr_key_i     (wr_key),
    .wr_page_i    (wr_page),
    .wdata_i      (sfr_wdata_i),
    .dbg_en_i     (dbg_en_i),
    .clk_ok_i     (clk_ok_i),
    .done_i       (fl_done_i),
    .mass_armed_o (mass_armed),
    .busy_o       (busy),
    .mass_stb_o   (fl_mass_erase_o),
    .page_stb_o   (fl_page_erase_o)
  );

  flash_seq_steer #(.ADDR_W(ADDR_W)) u_steer (
    .pwe_i       (pwe),
    .clk_ok_i    (clk_ok_i),
    .irq_off_i   (irq_off_i),
    .busy_i      (busy),
    .xst_we_i    (xst_we_i),
    .xst_addr_i  (xst_addr_i),
    .xst_wdata_i (xst_wdata_i),
    .ram_we_o    (ram_we_o),
    .ram_addr_o  (ram_addr_o),
    .ram_wdata_o (ram_wdata_o),
    .fl_prog_o   (fl_prog_o),
    .fl_addr_o   (fl_addr_o),
    .fl_wdata_o  (fl_wdata_o)
  );

  assign busy_o = busy;
endmodule

// File: rtl/flash_seq_chk.sv
module flash_seq_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic dbg_en_i,
  input logic clk_ok_i,
  input logic irq_off_i,
  input logic fl_done_i,
  input logic fl_mass_erase_o,
  input logic fl_page_erase_o,
  input logic fl_prog_o,
  input logic ram_we_o,
  input logic busy_o,
  input logic proto_err_o
);
  // R2
  strobe_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({fl_mass_erase_o, fl_page_erase_o}));

  // R7
  launch_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fl_mass_erase_o || fl_page_erase_o) |-> (busy_o && !$past(busy_o)));

  // R7
  busy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !fl_done_i) |=> busy_o);

  // R3
  mass_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fl_mass_erase_o |-> ($past(dbg_en_i) && $past(clk_ok_i)));

  // R6
  page_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fl_page_erase_o |-> $past(clk_ok_i));

  // R8
  one_target_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(fl_prog_o && ram_we_o));

  // R9
  err_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(proto_err_o) |-> !$past(irq_off_i));
endmodule

bind flash_seq_ctrl flash_seq_chk u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .dbg_en_i        (dbg_en_i),
  .clk_ok_i        (clk_ok_i),
  .irq_off_i       (irq_off_i),
  .fl_done_i       (fl_done_i),
  .fl_mass_erase_o (fl_mass_erase_o),
  .fl_page_erase_o (fl_page_erase_o),
  .fl_prog_o       (fl_prog_o),
  .ram_we_o        (ram_we_o),
  .busy_o          (busy_o),
  .proto_err_o     (proto_err_o)
);

// File: tb/flash_seq_ctrl_tb.sv
module flash_seq_ctrl_tb;
  localparam logic [7:0] A_CTL = 8'hC0, A_KEY = 8'hC1, A_PAGE = 8'hC2;

  logic clk = 0, rst_n = 0;
  logic sfr_we = 0; logic [7:0] sfr_addr = 0, sfr_wdata = 0; logic [7:0] sfr_rdata;
  logic dbg_en = 1, clk_ok = 1, irq_off = 1;
  logic xst_we = 0; logic [15:0] xst_addr = 0; logic [7:0] xst_wdata = 0;
  logic ram_we, fl_prog, mass_stb, page_stb, fl_done = 0, busy, perr;
  logic [15:0] ram_addr, fl_addr; logic [7:0] ram_wdata, fl_wdata; logic [6:0] fl_page;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  flash_seq_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .sfr_we_i(sfr_we), .sfr_addr_i(sfr_addr),
    .sfr_wdata_i(sfr_wdata), .sfr_rdata_o(sfr_rdata), .dbg_en_i(dbg_en),
    .clk_ok_i(clk_ok), .irq_off_i(irq_off), .xst_we_i(xst_we), .xst_addr_i(xst_addr),
    .xst_wdata_i(xst_wdata), .ram_we_o(ram_we), .ram_addr_o(ram_addr),
    .ram_wdata_o(ram_wdata), .fl_prog_o(fl_prog), .fl_addr_o(fl_addr),
    .fl_wdata_o(fl_wdata), .fl_mass_erase_o(mass_stb), .fl_page_erase_o(page_stb),
    .fl_page_o(fl_page), .fl_done_i(fl_done), .busy_o(busy), .proto_err_o(perr)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // one write, held across one rising edge; returns at the following falling edge
  task automatic wr(logic [7:0] a, logic [7:0] d);
    @(negedge clk); sfr_we = 1; sfr_addr = a; sfr_wdata = d;
    @(negedge clk); sfr_we = 0;
  endtask

  task automatic rd(logic [7:0] a, output logic [7:0] d);
    sfr_addr = a; #1 d = sfr_rdata;
  endtask

  task automatic finish_erase();
    fl_done = 1; @(negedge clk); fl_done = 0;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    rd(A_CTL, d);
    chk("R1 ctl", d, 8'h00);
    chk("R1 outs", {busy, perr, mass_stb, page_stb, ram_we, fl_prog}, 0);
  endtask

  task automatic t_mass();
    logic [7:0] d;
    dbg_en = 1; clk_ok = 1;
    wr(A_CTL, 8'h02); rd(A_CTL, d);
    chk("R2 armed bit", d[1], 1);
    wr(A_KEY, 8'hAA);
    chk("R2 strobe", {mass_stb, page_stb, busy}, 3'b101);
    rd(A_CTL, d);
    chk("R2 self-clear", d[1], 0);
    chk("R2 busy bit", d[2], 1);
    @(negedge clk);
    chk("R2 one cycle", mass_stb, 0);
    repeat (3) @(negedge clk);
    chk("R7 busy holds", busy, 1);
    finish_erase();
    chk("R7 busy clears", busy, 0);
  endtask

  task automatic t_mass_nodbg();
    logic [7:0] d;
    dbg_en = 0;
    wr(A_CTL, 8'h02);
    wr(A_KEY, 8'hAA);
    chk("R3 no erase", {mass_stb, busy}, 0);
    rd(A_CTL, d);
    chk("R3 disarmed", d[1], 0);
    dbg_en = 1;
    wr(A_KEY, 8'hAA);
    chk("R5 stale key", {mass_stb, busy}, 0);
  endtask

  task automatic t_page();
    logic [7:0] d;
    wr(A_PAGE, 8'h2B); rd(A_PAGE, d);
    chk("R10 readback", d, 8'h2A);
    wr(A_KEY, 8'h55);
    chk("R4 strobe", {page_stb, mass_stb, busy}, 3'b101);
    chk("R4 page", fl_page, 7'h15);
    @(negedge clk);
    chk("R4 one cycle", page_stb, 0);
    wr(A_PAGE, 8'h80);
    chk("R7 page ignored", fl_page, 7'h15);
    wr(A_KEY, 8'h55);
    chk("R7 key ignored", page_stb, 0);
    finish_erase();
    wr(A_KEY, 8'h55);
    chk("R7 no leftover arm", {page_stb, busy}, 0);
  endtask

  task automatic t_wrong_key();
    logic [7:0] d;
    wr(A_PAGE, 8'h04);
    wr(A_KEY, 8'hAA);
    chk("R5 mismatch", {mass_stb, page_stb, busy}, 0);
    wr(A_KEY, 8'h55);
    chk("R5 disarmed", {page_stb, busy}, 0);
    wr(A_CTL, 8'h02);
    wr(A_KEY, 8'h13);
    rd(A_CTL, d);
    chk("R5 mass disarmed", d[1], 0);
  endtask

  task automatic t_clk_block();
    clk_ok = 0;
    wr(A_PAGE, 8'h06);
    wr(A_KEY, 8'h55);
    chk("R6 erase blocked", {page_stb, busy}, 0);
    wr(A_CTL, 8'h01);
    xst_we = 1; xst_addr = 16'h1234; xst_wdata = 8'h5A; #1;
    chk("R6 prog blocked", {fl_prog, ram_we}, 0);
    @(negedge clk); xst_we = 0;
    wr(A_CTL, 8'h00);
    clk_ok = 1;
  endtask

  task automatic t_steer();
    @(negedge clk);
    xst_we = 1; xst_addr = 16'h0100; xst_wdata = 8'hC3; #1;
    chk("R8 ram path", {ram_we, fl_prog}, 2'b10);
    chk("R8 ram addr", {ram_addr, ram_wdata}, 24'h0100C3);
    @(negedge clk); xst_we = 0;
    wr(A_CTL, 8'h01);
    xst_we = 1; xst_addr = 16'hFE01; xst_wdata = 8'h7E; #1;
    chk("R8 flash path", {ram_we, fl_prog}, 2'b01);
    chk("R8 flash addr", {fl_addr, fl_wdata}, 24'hFE017E);
    @(negedge clk); xst_we = 0;
    wr(A_CTL, 8'h00);
  endtask

  task automatic t_proto();
    logic [7:0] d;
    irq_off = 0;
    wr(A_CTL, 8'h01);
    @(negedge clk);
    chk("R9 err set", perr, 1);
    xst_we = 1; xst_addr = 16'h0200; #1;
    chk("R9 prog blocked", {fl_prog, ram_we}, 0);
    @(negedge clk); xst_we = 0;
    irq_off = 1;
    wr(A_CTL, 8'h00);
    rd(A_CTL, d);
    chk("R9 sticky", d[3], 1);
    wr(A_CTL, 8'h08);
    chk("R9 cleared", perr, 0);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_mass();
    t_mass_nodbg();
    t_page();
    t_wrong_key();
    t_clk_block();
    t_steer();
    t_proto();
    summary();
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    summary();
  end
endmodule